// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Table

This block holds a gamma correction table for a pixel pipeline in two complete copies, bank A and bank B, each with separate red, green and blue channels. A host loads one bank through a small register-write port while the pixel path reads the other. Every channel entry is written by the same data value, with a three-bit channel mask selecting which channels take it. A write index advances by one after each data write, so a table streams in through back-to-back writes. The host can reload the index between channels to fill red, green and blue with different curves.

A display-control register holds the requested lookup mode (pass-through or table lookup) and the requested read bank. Neither takes effect until a frame-start pulse copies both into the current setting. The current setting is visible on status outputs. A host can therefore rewrite the idle bank during a frame and switch banks cleanly at the next frame boundary.

The pixel side takes a table index and an input pixel. One clock later it returns either the input pixel unchanged or the three entries of the current bank at that index.

Top module: `gamma_lut_dbuf`

## Requirements
- R1: After reset, all pixel outputs are 0, `cur_mode` is 0 (pass-through) and `cur_sel` is 0 (bank A). The write mask resets to 7 and the write index resets to 0.
- R2: When `cur_mode` is anything other than 2, each pixel output equals the matching pixel input of the previous clock.
- R3: When `cur_mode` is 2, each pixel output equals the entry of the current bank (`cur_sel` 0 = A, 1 = B) at the previous clock's `pix_idx`. An index beyond the last entry reads as 0.
- R4: A write to register address 0 sets the channel mask from `reg_wdata[2:0]`: bit 2 enables red, bit 1 green and bit 0 blue. A data write (address 2) stores `reg_wdata` only into the enabled channels, and disabled channels keep their contents.
- R5: Each data write stores at the current write index and then increments the index, so consecutive data writes fill consecutive entries.
- R6: A write to address 1 loads the write index from `reg_wdata`. A value above DEPTH is clamped to DEPTH.
- R7: `reg_wdata[4]` of an address-0 write picks the bank that data writes go to: 0 for A, 1 for B.
- R8: A write to address 3 requests a mode (`reg_wdata[1:0]`) and a read bank (`reg_wdata[4]`). `cur_mode` and `cur_sel` take the requested values only at a clock where `frame_start` is high, and otherwise hold.
- R9: Data writes into the bank that is not current leave the pixel outputs unchanged.
- R10: Once the write index has passed the last entry (index DEPTH), a data write stores nothing and the index stays at DEPTH without wrapping to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register address: 0 write control, 1 write index, 2 data, 3 display control |
| reg_wdata | input | DATA_W | Host write data |
| frame_start | input | 1 | Frame boundary pulse; applies the requested mode and bank |
| pix_idx | input | IDX_W | Table index for the pixel lookup |
| pix_in_r | input | DATA_W | Input red component |
| pix_in_g | input | DATA_W | Input green component |
| pix_in_b | input | DATA_W | Input blue component |
| pix_out_r | output | DATA_W | Output red component, one clock latency |
| pix_out_g | output | DATA_W | Output green component, one clock latency |
| pix_out_b | output | DATA_W | Output blue component, one clock latency |
| cur_mode | output | 2 | Mode currently in effect |
| cur_sel | output | 1 | Bank currently read by the pixel path |

## Verification
The bench builds the block with DEPTH = 9 and DATA_W = 10. With a table this small, every entry of both banks and all three channels can be written and read back after each reload. The short depth also lets the bench reach the end-of-table write, the clamped index load and the non-wrapping index within a few writes. It mixes all-channel and single-channel loads with a two-channel mask, and it moves the requested bank and mode both with and without a frame pulse.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int NUM_BANKS = 2;
   localparam int NUM_CH    = 3;   // 0 red, 1 green, 2 blue

   typedef enum logic [1:0] {
      ADDR_WCTL  = 2'd0,
      ADDR_WIDX  = 2'd1,
      ADDR_WDATA = 2'd2,
      ADDR_DCTL  = 2'd3
   } reg_addr_e;

   localparam logic [1:0] MODE_BYPASS = 2'd0;
   localparam logic [1:0] MODE_RAM    = 2'd2;
endpackage

// File: rtl/lut_wr_ctrl.sv
module lut_wr_ctrl
   import gamma_lut_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 257,
   parameter int IDX_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [2:0]        wr_mask,
   output logic              host_bank,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              data_req,
   output logic              data_fire
);
   localparam logic [IDX_W-1:0]  END_IDX  = IDX_W'(DEPTH);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
   localparam logic [DATA_W-1:0] END_VAL  = DATA_W'(DEPTH);

   assign data_req  = reg_we && (reg_addr == ADDR_WDATA);
   assign data_fire = data_req && (wr_idx <= LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_mask   <= 3'b111;
         host_bank <= 1'b0;
         wr_idx    <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            ADDR_WCTL: begin
               wr_mask   <= reg_wdata[2:0];
               host_bank <= reg_wdata[4];
            end
            ADDR_WIDX:
               wr_idx <= (reg_wdata > END_VAL) ? END_IDX : reg_wdata[IDX_W-1:0];
            ADDR_WDATA:
               if (wr_idx <= LAST_IDX) wr_idx <= wr_idx + 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lut_chan_ram.sv
module lut_chan_ram #(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 257,
   parameter int AW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (waddr <= LAST)) mem[waddr] <= wdata;
   end

   assign rdata = (raddr <= LAST) ? mem[raddr] : '0;
endmodule

// File: rtl/frame_sel_latch.sv
module frame_sel_latch
   import gamma_lut_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [1:0] mode_wdata,
   input  logic       sel_wdata,
   input  logic       frame_start,
   output logic [1:0] cur_mode,
   output logic       cur_sel
);
   logic [1:0] req_mode;
   logic       req_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_mode <= MODE_BYPASS;
         req_sel  <= 1'b0;
         cur_mode <= MODE_BYPASS;
         cur_sel  <= 1'b0;
      end else begin
         if (reg_we && (reg_addr == ADDR_DCTL)) begin
            req_mode <= mode_wdata;
            req_sel  <= sel_wdata;
         end
         if (frame_start) begin
            cur_mode <= req_mode;
            cur_sel  <= req_sel;
         end
      end
   end
endmodule

// File: rtl/gamma_lut_dbuf.sv
module gamma_lut_dbuf
   import gamma_lut_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 257,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              frame_start,
   input  logic [IDX_W-1:0]  pix_idx,
   input  logic [DATA_W-1:0] pix_in_r,
   input  logic [DATA_W-1:0] pix_in_g,
   input  logic [DATA_W-1:0] pix_in_b,
   output logic [DATA_W-1:0] pix_out_r,
   output logic [DATA_W-1:0] pix_out_g,
   output logic [DATA_W-1:0] pix_out_b,
   output logic [1:0]        cur_mode,
   output logic              cur_sel
);
   initial begin
      if (DEPTH < 2)             $fatal(1, "gamma_lut_dbuf: DEPTH must be at least 2");
      if (DATA_W < 8)            $fatal(1, "gamma_lut_dbuf: DATA_W must be at least 8");
      if (IDX_W > DATA_W)        $fatal(1, "gamma_lut_dbuf: index wider than data");
   end

   logic [2:0]        wr_mask;
   logic              host_bank;
   logic [IDX_W-1:0]  host_idx;
   logic              data_req;
   logic              data_fire;
   logic [DATA_W-1:0] rd_q   [NUM_BANKS][NUM_CH];
   logic [DATA_W-1:0] pin    [NUM_CH];
   logic [DATA_W-1:0] pout_q [NUM_CH];

   lut_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr (
      .clk      (clk),
      .rst      (rst),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .wr_mask  (wr_mask),
      .host_bank(host_bank),
      .wr_idx   (host_idx),
      .data_req (data_req),
      .data_fire(data_fire)
   );

   frame_sel_latch u_sel (
      .clk        (clk),
      .rst        (rst),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .mode_wdata (reg_wdata[1:0]),
      .sel_wdata  (reg_wdata[4]),
      .frame_start(frame_start),
      .cur_mode   (cur_mode),
      .cur_sel    (cur_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         lut_chan_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(IDX_W)) u_ram (
            .clk  (clk),
            .we   (data_fire && (host_bank == 1'(b)) && wr_mask[2-c]),
            .waddr(host_idx),
            .wdata(reg_wdata),
            .raddr(pix_idx),
            .rdata(rd_q[b][c])
         );
      end
   end

   assign pin[0] = pix_in_r;
   assign pin[1] = pix_in_g;
   assign pin[2] = pix_in_b;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_out
      always_ff @(posedge clk) begin
         if (rst)                      pout_q[c] <= '0;
         else if (cur_mode == MODE_RAM) pout_q[c] <= rd_q[cur_sel][c];
         else                          pout_q[c] <= pin[c];
      end
   end

   assign pix_out_r = pout_q[0];
   assign pix_out_g = pout_q[1];
   assign pix_out_b = pout_q[2];
endmodule

// File: rtl/gamma_lut_dbuf_chk.sv
module gamma_lut_dbuf_chk #(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 257,
   parameter int IDX_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              data_req,
   input logic [IDX_W-1:0]  host_idx,
   input logic              frame_start,
   input logic [1:0]        cur_mode,
   input logic              cur_sel,
   input logic [DATA_W-1:0] pix_in_r,
   input logic [DATA_W-1:0] pix_out_r,
   input logic [DATA_W-1:0] pix_in_b,
   input logic [DATA_W-1:0] pix_out_b
);
   localparam logic [IDX_W-1:0] END_IDX = IDX_W'(DEPTH);

   // R5
   idx_step_chk: assert property (@(posedge clk) disable iff (rst)
      (data_req && host_idx < END_IDX) |=> host_idx == IDX_W'($past(host_idx) + 1'b1));

   // R10
   idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (data_req && host_idx == END_IDX) |=> host_idx == END_IDX);

   // R6
   idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      host_idx <= END_IDX);

   // R8
   cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !frame_start |=> ($stable(cur_mode) && $stable(cur_sel)));

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_mode != 2'd2) |=> (pix_out_r == $past(pix_in_r) && pix_out_b == $past(pix_in_b)));
endmodule

bind gamma_lut_dbuf gamma_lut_dbuf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .data_req   (data_req),
   .host_idx   (host_idx),
   .frame_start(frame_start),
   .cur_mode   (cur_mode),
   .cur_sel    (cur_sel),
   .pix_in_r   (pix_in_r),
   .pix_out_r  (pix_out_r),
   .pix_in_b   (pix_in_b),
   .pix_out_b  (pix_out_b)
);

// File: tb/gamma_lut_dbuf_tb.sv
module gamma_lut_dbuf_tb;
   localparam int DW = 10;
   localparam int DP = 9;
   localparam int IW = $clog2(DP + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic          frame_start = 1'b0;
   logic [IW-1:0] pix_idx = '0;
   logic [DW-1:0] pin_r = '0, pin_g = '0, pin_b = '0;
   logic [DW-1:0] pout_r, pout_g, pout_b;
   logic [1:0]    cur_mode;
   logic          cur_sel;

   int total = 0;
   int bad   = 0;

   // bench model
   int m_mask = 7, m_hb = 0, m_idx = 0;
   int m_req_mode = 0, m_req_sel = 0, m_mode = 0, m_sel = 0;
   int exp_m [2][3][DP];

   always #5 clk = ~clk;

   gamma_lut_dbuf #(.DATA_W(DW), .DEPTH(DP)) u_dut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .frame_start(frame_start), .pix_idx(pix_idx),
      .pix_in_r(pin_r), .pix_in_g(pin_g), .pix_in_b(pin_b),
      .pix_out_r(pout_r), .pix_out_g(pout_g), .pix_out_b(pout_b),
      .cur_mode(cur_mode), .cur_sel(cur_sel)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_wr(int addr, int data);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'(addr); reg_wdata = DW'(data);
      @(negedge clk);
      reg_we = 1'b0;
      if (addr == 0) begin m_mask = data & 7; m_hb = (data >> 4) & 1; end
      if (addr == 1) m_idx = (data > DP) ? DP : data;
      if (addr == 2 && m_idx < DP) begin
         for (int c = 0; c < 3; c++)
            if (((m_mask >> (2 - c)) & 1) == 1) exp_m[m_hb][c][m_idx] = data;
         m_idx++;
      end
      if (addr == 3) begin m_req_mode = data & 3; m_req_sel = (data >> 4) & 1; end
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      m_mode = m_req_mode; m_sel = m_req_sel;
   endtask

   task automatic look(string req, int idx, int r, int g, int b);
      int er, eg, eb;
      @(negedge clk);
      pix_idx = IW'(idx); pin_r = DW'(r); pin_g = DW'(g); pin_b = DW'(b);
      @(negedge clk);
      if (m_mode == 2) begin
         er = (idx < DP) ? exp_m[m_sel][0][idx] : 0;
         eg = (idx < DP) ? exp_m[m_sel][1][idx] : 0;
         eb = (idx < DP) ? exp_m[m_sel][2][idx] : 0;
      end else begin
         er = r; eg = g; eb = b;
      end
      check({req, " red"},   int'(pout_r), er);
      check({req, " green"}, int'(pout_g), eg);
      check({req, " blue"},  int'(pout_b), eb);
   endtask

   task automatic status(string req);
      check({req, " cur_mode"}, int'(cur_mode), m_mode);
      check({req, " cur_sel"},  int'(cur_sel),  m_sel);
   endtask

   task automatic sweep(string req);
      for (int i = 0; i < DP; i++) look(req, i, 3 * i + 1, 5 * i + 2, 7 * i + 3);
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 out_r", int'(pout_r), 0);
      check("R1 out_g", int'(pout_g), 0);
      check("R1 out_b", int'(pout_b), 0);
      check("R1 cur_mode", int'(cur_mode), 0);
      check("R1 cur_sel", int'(cur_sel), 0);
      rst = 1'b0;

      // R2 pass-through
      for (int v = 0; v < 8; v++) look("R2 bypass", v, v * 131, 1023 - v * 77, v * 29 + 500);

      // R5 R7 fill bank A with default mask (R1: mask resets to 7, index to 0)
      for (int i = 0; i < DP; i++) reg_wr(2, (i * 37 + 5) % 1024);
      // R8 requested RAM mode not applied without frame pulse
      reg_wr(3, 2);
      look("R8 before frame", 2, 11, 22, 33);
      status("R8 before frame");
      frame();
      status("R8 after frame");
      sweep("R3 bank A");

      // R4 R6 R7 per-channel load of bank B
      reg_wr(0, 16 | 4); reg_wr(1, 0);
      for (int i = 0; i < DP; i++) reg_wr(2, i * 11 + 100);
      reg_wr(0, 16 | 2); reg_wr(1, 0);
      for (int i = 0; i < DP; i++) reg_wr(2, i * 53 + 7);
      reg_wr(0, 16 | 1); reg_wr(1, 0);
      for (int i = 0; i < DP; i++) reg_wr(2, 1000 - i * 9);
      // R9 bank A still shown after writes into bank B
      sweep("R9 inactive bank");
      reg_wr(3, 16 | 2);
      look("R8 sel pending", 4, 0, 0, 0);
      frame();
      status("R8 sel applied");
      sweep("R4 bank B per channel");

      // R10 end of table on bank A (inactive)
      reg_wr(0, 7); reg_wr(1, 7);
      reg_wr(2, 900); reg_wr(2, 901); reg_wr(2, 902);
      // R6 clamp of an oversized index, then ignored write
      reg_wr(1, 15); reg_wr(2, 555);
      reg_wr(3, 2);
      frame();
      look("R10 last entry", DP - 1, 0, 0, 0);
      look("R10 no wrap", 0, 0, 0, 0);
      look("R10 entry 7", 7, 0, 0, 0);
      look("R3 out of range idx", DP + 3, 0, 0, 0);

      // R4 two-channel mask (red+blue) on bank B
      reg_wr(0, 16 | 5); reg_wr(1, 3); reg_wr(2, 321);
      reg_wr(3, 16 | 2);
      frame();
      sweep("R4 mask red+blue");

      // R2 other non-RAM mode values
      reg_wr(3, 1); frame(); status("R8 mode 1");
      look("R2 mode 1", 5, 1, 2, 3);
      reg_wr(3, 3); frame();
      look("R2 mode 3", 5, 900, 800, 700);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule